// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a serial test port that conforms to the usual boundary-scan controller model. It is driven by a test clock, a mode-select line and a serial data input. Inside are the 16-state controller, a 3-bit instruction register, a 1-bit bypass path, a 32-bit identification word and a boundary register. The boundary register takes a snapshot of a parallel pin vector when the controller passes through its capture state. The current instruction picks the register that feeds the serial output. Two of the sample opcodes also raise a flag that forces the surrounding data outputs to High-Z.

The opcode map is not the standard one. Two codes select sampling with outputs floated. One code selects identification. One code selects plain sampling. The other four codes give the 1-bit bypass path, and the reserved code is one of these four. There is no dedicated test-reset pin. An active-low power-on reset and the five-ones rule on the mode line are the only ways to reach the reset state. Boundary positions marked as unconnected always capture 0.

Top module: `scan_tap`

## Requirements
- R1: After power-on reset (`por_n` low), the controller is in Test-Logic-Reset and the active opcode is 001 (identification). `tdo_oe` and `outs_hiz` are both 0.
- R2: Five consecutive rising `tck` edges with `tms`=1 bring the controller to Test-Logic-Reset from any state. Entering that state makes opcode 001 active, which clears `outs_hiz`.
- R3: In Capture-IR the instruction shift register loads 3'b001. Scanning the instruction register therefore shifts out 1, 0, 0 on `tdo`, least significant bit first.
- R4: With opcode 001, a data-register scan shifts out the 32-bit word {revision[31:28], configuration[27:18], vendor[17:12], manufacturer[11:1], 1'b1}, bit 0 first. With default parameters this word is 32'h0410019D.
- R5: Opcodes 000 and 010 connect the boundary register to `tdo` and drive `outs_hiz` to 1.
- R6: Opcode 100 connects the boundary register to `tdo` and leaves `outs_hiz` at 0.
- R7: Opcodes 011, 110 and 111, and the reserved code 101, select the 1-bit bypass path. It captures 0 and delays `tdi` by exactly one shift. `outs_hiz` is 0.
- R8: In Capture-DR the boundary register loads `pin_vec`, with the positions set in `NC_MASK` forced to 0. It shifts out bit 0 first, and `tdi` enters at the top bit.
- R9: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 only while the controller is in Shift-DR or Shift-IR.
- R10: A newly shifted opcode takes effect only when the controller leaves Update-IR. While the new opcode is being shifted in, `outs_hiz` keeps the value set by the previous instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_vec | input | BSR_LEN | Parallel pin values captured by the boundary register |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` (1 = drive) |
| outs_hiz | output | 1 | Forces the functional data outputs to High-Z |

## Verification
Shifting a new opcode into the instruction register can overlap with the effect of the instruction that is still active. While the bits of a bypass code pass through Shift-IR and Exit1-IR, a sample-with-float instruction must keep `outs_hiz` high. The bench loads opcode 000 first. It then scans in 011 and samples `outs_hiz` after every edge. The flag must stay at 1 through Update-IR and drop only on the edge that leaves it. A separate case overlaps the five-ones reset with a pending Shift-DR. The bench checks that the float flag clears on entry to Test-Logic-Reset and that the next scan returns the identification word.

// File: rtl/scan_tap.sv
module scan_tap #(
  parameter int BSR_LEN = 70,
  parameter logic [BSR_LEN-1:0] NC_MASK = BSR_LEN'(1) << 54,
  parameter logic [3:0]  ID_REV  = 4'h0,
  parameter logic [9:0]  ID_CFG  = 10'h104,
  parameter logic [5:0]  ID_VEND = 6'h00,
  parameter logic [10:0] ID_MFR  = 11'h0CE
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_vec,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               outs_hiz
);
  localparam logic [31:0] ID_WORD = {ID_REV, ID_CFG, ID_VEND, ID_MFR, 1'b1};
  localparam logic [2:0]  OP_ID   = 3'b001;

  typedef enum logic [3:0] {
    S_TLR  = 4'd0,  S_RTI  = 4'd1,  S_SDS  = 4'd2,  S_CDR  = 4'd3,
    S_SHDR = 4'd4,  S_E1DR = 4'd5,  S_PDR  = 4'd6,  S_E2DR = 4'd7,
    S_UDR  = 4'd8,  S_SIS  = 4'd9,  S_CIR  = 4'd10, S_SHIR = 4'd11,
    S_E1IR = 4'd12, S_PIR  = 4'd13, S_E2IR = 4'd14, S_UIR  = 4'd15
  } tap_st_e;

  tap_st_e state_q, state_d;
  logic [2:0] ir_q, ir_sr;
  logic       byp_q;
  logic [31:0] id_sr;
  logic [BSR_LEN-1:0] bsr_sr;
  logic tdo_q, oe_q;
  logic is_bsr, is_id, is_byp, dr_bit;

  always_comb begin
    case (state_q)
      S_TLR:  state_d = tms ? S_TLR  : S_RTI;
      S_RTI:  state_d = tms ? S_SDS  : S_RTI;
      S_SDS:  state_d = tms ? S_SIS  : S_CDR;
      S_CDR:  state_d = tms ? S_E1DR : S_SHDR;
      S_SHDR: state_d = tms ? S_E1DR : S_SHDR;
      S_E1DR: state_d = tms ? S_UDR  : S_PDR;
      S_PDR:  state_d = tms ? S_E2DR : S_PDR;
      S_E2DR: state_d = tms ? S_UDR  : S_SHDR;
      S_UDR:  state_d = tms ? S_SDS  : S_RTI;
      S_SIS:  state_d = tms ? S_TLR  : S_CIR;
      S_CIR:  state_d = tms ? S_E1IR : S_SHIR;
      S_SHIR: state_d = tms ? S_E1IR : S_SHIR;
      S_E1IR: state_d = tms ? S_UIR  : S_PIR;
      S_PIR:  state_d = tms ? S_E2IR : S_PIR;
      S_E2IR: state_d = tms ? S_UIR  : S_SHIR;
      default: state_d = tms ? S_SDS : S_RTI;
    endcase
  end

  assign is_bsr   = (ir_q == 3'b000) || (ir_q == 3'b010) || (ir_q == 3'b100);
  assign is_id    = (ir_q == OP_ID);
  assign is_byp   = !is_bsr && !is_id;
  assign outs_hiz = !ir_q[2] && !ir_q[0];
  assign dr_bit   = is_bsr ? bsr_sr[0] : (is_id ? id_sr[0] : byp_q);

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) state_q <= S_TLR;
    else        state_q <= state_d;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_q  <= OP_ID;
      ir_sr <= 3'b001;
    end else begin
      if (state_d == S_TLR)       ir_q  <= OP_ID;
      else if (state_q == S_UIR)  ir_q  <= ir_sr;
      if (state_q == S_CIR)       ir_sr <= 3'b001;
      else if (state_q == S_SHIR) ir_sr <= {tdi, ir_sr[2:1]};
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp_q  <= 1'b0;
      id_sr  <= '0;
      bsr_sr <= '0;
    end else if (state_q == S_CDR) begin
      if (is_byp) byp_q  <= 1'b0;
      if (is_id)  id_sr  <= ID_WORD;
      if (is_bsr) bsr_sr <= pin_vec & ~NC_MASK;
    end else if (state_q == S_SHDR) begin
      if (is_byp) byp_q  <= tdi;
      if (is_id)  id_sr  <= {tdi, id_sr[31:1]};
      if (is_bsr) bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
    end
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= (state_q == S_SHDR) || (state_q == S_SHIR);
      if (state_q == S_SHIR)      tdo_q <= ir_sr[0];
      else if (state_q == S_SHDR) tdo_q <= dr_bit;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;
endmodule

module scan_tap_chk (
  input logic       tck,
  input logic       por_n,
  input logic       tms,
  input logic [3:0] state,
  input logic [2:0] ir,
  input logic [2:0] ir_sr,
  input logic       byp,
  input logic       tdo_oe,
  input logic       outs_hiz
);
  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge por_n)
    if (!por_n)   ones_q <= 3'd0;
    else if (!tms) ones_q <= 3'd0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;

  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!por_n)
    (ones_q == 3'd5) |-> (state == 4'd0));

  a_r3_capture_ir: assert property (@(posedge tck) disable iff (!por_n)
    (state == 4'd10) |=> (ir_sr == 3'b001));

  a_r7_bypass_zero: assert property (@(posedge tck) disable iff (!por_n)
    (state == 4'd3 && ir != 3'b000 && ir != 3'b001 && ir != 3'b010 && ir != 3'b100)
    |=> (byp == 1'b0));

  a_r9_oe_in_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe == (state == 4'd4 || state == 4'd11));

  a_r10_hiz_held: assert property (@(posedge tck) disable iff (!por_n)
    (state != 4'd15 && state != 4'd9 && state != 4'd0) |=> $stable(outs_hiz));
endmodule

bind scan_tap scan_tap_chk u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .state(state_q), .ir(ir_q),
  .ir_sr(ir_sr), .byp(byp_q), .tdo_oe(tdo_oe), .outs_hiz(outs_hiz)
);

// File: tb/tb_scan_tap.sv
module tb_scan_tap;
  localparam int L_BSR = 70;
  localparam logic [31:0] EXP_ID = {4'h0, 10'h104, 6'h00, 11'h0CE, 1'b1};
  localparam logic [L_BSR-1:0] EXP_NC = L_BSR'(1) << 54;
  localparam logic [127:0] PAT = 128'hC3A596F00FF15A3CE71B2D489C0F6B35;
  // {opcode, kind (0 boundary, 1 id, 2 bypass), float flag}
  localparam logic [5:0] VEC [8] = '{
    {3'b000, 2'd0, 1'b1}, {3'b001, 2'd1, 1'b0}, {3'b010, 2'd0, 1'b1},
    {3'b011, 2'd2, 1'b0}, {3'b100, 2'd0, 1'b0}, {3'b101, 2'd2, 1'b0},
    {3'b110, 2'd2, 1'b0}, {3'b111, 2'd2, 1'b0}};

  logic tck = 0, por_n = 0, tms = 1, tdi = 1;
  logic [L_BSR-1:0] pins;
  logic tdo, tdo_oe, outs_hiz;
  logic s_tdo, s_oe;
  int total = 0, bad = 0, edge_mis = 0, oe_mis = 0;

  scan_tap dut (.tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_vec(pins),
                .tdo(tdo), .tdo_oe(tdo_oe), .outs_hiz(outs_hiz));

  always #5 tck = ~tck;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    @(negedge tck); #1;
    s_tdo = tdo; s_oe = tdo_oe;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    tick(1, 1); tick(1, 1); tick(0, 1); tick(0, 1);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i]); cap[i] = s_tdo;
      if (tdo !== s_tdo) edge_mis++;
    end
    tick(1, 1); tick(0, 1);
  endtask

  task automatic scan_dr(input int n, output logic [127:0] got);
    got = '0;
    tick(1, 1); tick(0, 1); tick(0, 1);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, PAT[i]); got[i] = s_tdo;
      if (!s_oe) oe_mis++;
      if (tdo !== s_tdo) edge_mis++;
    end
    tick(1, 1); tick(0, 1);
    if (s_oe) oe_mis++;
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] cap;
    logic [127:0] got, exp, capv;
    int len;
    pins = L_BSR'(70'h3A5C3F0F1E96B4C7D2) | EXP_NC;
    #13;
    chk("R1 oe at reset", tdo_oe, 0);
    chk("R1 hiz at reset", outs_hiz, 0);
    #10 por_n = 1;
    tick(0, 1);
    chk("R1 hiz after release", outs_hiz, 0);
    scan_dr(40, got);
    chk("R1 R4 default id", got[31:0], EXP_ID);

    for (int v = 0; v < 8; v++) begin
      load_ir(VEC[v][5:3], cap);
      chk("R3 captured ir", cap, 3'b001);
      chk("R5 R6 R7 float flag", outs_hiz, VEC[v][0]);
      len  = (VEC[v][2:1] == 2'd0) ? L_BSR : (VEC[v][2:1] == 2'd1) ? 32 : 1;
      capv = (VEC[v][2:1] == 2'd0) ? 128'(pins & ~EXP_NC) :
             (VEC[v][2:1] == 2'd1) ? 128'(EXP_ID) : 128'd0;
      exp = '0;
      for (int i = 0; i < len + 8; i++) exp[i] = (i < len) ? capv[i] : PAT[i - len];
      scan_dr(len + 8, got);
      chk("R4 R5 R6 R7 R8 scan data", got, exp);
    end

    load_ir(3'b000, cap);
    chk("R5 float before overlap", outs_hiz, 1);
    tick(1, 1); tick(1, 1); tick(0, 1); tick(0, 1);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, 3'b011 >> i);
      chk("R10 float held in shift", outs_hiz, 1);
    end
    tick(1, 1);
    chk("R10 float held in update", outs_hiz, 1);
    tick(0, 1);
    chk("R10 float dropped after update", outs_hiz, 0);

    load_ir(3'b010, cap);
    tick(1, 1); tick(0, 1); tick(0, 1);
    for (int i = 0; i < 5; i++) tick(1, 1);
    chk("R2 float cleared in reset", outs_hiz, 0);
    chk("R9 oe low in reset", tdo_oe, 0);
    tick(0, 1);
    scan_dr(32, got);
    chk("R2 id after five ones", got[31:0], EXP_ID);

    load_ir(3'b000, cap);
    tick(1, 1); tick(1, 1); tick(0, 1); tick(0, 1); tick(1, 1); tick(0, 1);
    for (int i = 0; i < 5; i++) tick(1, 1);
    chk("R2 reset from pause-ir", outs_hiz, 0);
    tick(0, 1);

    chk("R9 tdo stable at rising edge", edge_mis, 0);
    chk("R9 oe only in shift", oe_mis, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule